// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block sits between a clocked request port and an external asynchronous static RAM that has a 16-bit word and separate active-low strobes for its upper and lower bytes. A client presents a request with a read/write flag, an 18-bit word address, write data and a two-bit byte mask. The controller accepts the request only while it is idle. It then runs the memory's control lines through a fixed sequence of phases and reports completion with a one-cycle done pulse. For a read, that pulse comes with the returned word.

Every memory-side output is registered, so the strobes change cleanly on clock edges. Each phase length is an integer parameter counted in clock cycles: the read access window, the write-enable pulse width, and the idle gap after each transaction. A write passes through three phases: setup with write enable high, the pulse, and a one-cycle hold with write enable high. This keeps the address and data steady around the write enable's rising edge, and that edge is where the memory captures the data. Output enable stays high for the whole write, so the controller drives the data bus only while the memory's outputs are off. Chip enable goes high between transactions, which puts the memory in standby.

Top module: `asram_ctrl`

## Requirements
- R1: While reset is held and right after it is released, chip enable, output enable, write enable and both byte strobes are high. The ready output is high and done is low.
- R2: An accepted read holds chip enable and output enable low with write enable high for RD_CYC cycles. The data bus is sampled at the last clock edge of that window, and done is high in the cycle after the RD_CYC-th edge following the accepting edge.
- R3: Mask bit 0 enables the lower byte strobe and data bits 7:0, and mask bit 1 enables the upper byte strobe and bits 15:8. A write changes only the enabled bytes. A read returns zero in the disabled bytes.
- R4: An accepted write spends one setup cycle with chip enable low and write enable high. Write enable is then low for WR_CYC cycles, followed by one hold cycle with write enable high and chip enable still low. Done is high in the cycle after the (WR_CYC+2)-th edge following acceptance.
- R5: Output enable stays high for the whole of a write, and output enable and write enable are never low together. The controller drives the data bus only while output enable is high.
- R6: Write enable is low only while chip enable is low. The address and the driven write data do not change between two consecutive cycles that both have write enable low.
- R7: A request with mask 00 is a no-operation. Done is high in the cycle right after acceptance, no strobe falls (chip enable included), and memory contents are unchanged.
- R8: Ready is high only in the idle state. A request presented while ready is low has no effect.
- R9: After each done pulse, chip enable stays high and the bus stays undriven for TA_CYC cycles, and then ready returns high.
- R10: Done is a single-cycle pulse. The read data output keeps its value until the next read completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken when req_ready is high |
| req_ready | output | 1 | High while idle and able to accept |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte mask, bit 0 lower byte, bit 1 upper byte |
| rsp_rdata | output | 16 | Read data, zero in disabled bytes |
| rsp_done | output | 1 | One-cycle completion pulse |
| sram_ce_n | output | 1 | Chip enable, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_we_n | output | 1 | Write enable, active low |
| sram_ub_n | output | 1 | Upper byte strobe, active low |
| sram_lb_n | output | 1 | Lower byte strobe, active low |
| sram_addr | output | 18 | Memory address |
| sram_dq | inout | 16 | Bidirectional data bus |

## Verification
The bench targets single-byte writes followed by full-word readback. A design that swapped the lane strobes, or that wrote the masked byte anyway, returns a corrupted neighbour byte. It also targets the mask-00 request, which a faulty design turns into a real access that lowers chip enable or overwrites memory, and a request raised while the controller is busy, which a faulty design would accept and use to overwrite a location the bench reads later. Phase counts are checked cycle by cycle against the parameters: a miscounted window shows up as a wrong done latency, a wrong number of low write-enable or output-enable cycles, or ready returning too early after the turnaround.

// File: rtl/asram_pkg.sv
package asram_pkg;

    localparam int DATA_W = 16;
    localparam int LANES  = 2;
    localparam int LANE_W = DATA_W / LANES;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_WSETUP,
        ST_WPULSE,
        ST_WHOLD,
        ST_TURN
    } phase_e;

    typedef struct packed {
        logic ce_n;
        logic oe_n;
        logic we_n;
        logic ub_n;
        logic lb_n;
        logic drive;
    } strobe_t;

    localparam strobe_t STROBE_QUIET = '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1,
                                         ub_n: 1'b1, lb_n: 1'b1, drive: 1'b0};

    // Memory-side control levels that belong to a given phase.
    function automatic strobe_t strobes_for(phase_e ph, logic [LANES-1:0] be);
        strobe_t s;
        s = STROBE_QUIET;
        case (ph)
            ST_READ: begin
                s.ce_n = 1'b0;
                s.oe_n = 1'b0;
                s.lb_n = ~be[0];
                s.ub_n = ~be[1];
            end
            ST_WSETUP, ST_WHOLD: begin
                s.ce_n  = 1'b0;
                s.lb_n  = ~be[0];
                s.ub_n  = ~be[1];
                s.drive = 1'b1;
            end
            ST_WPULSE: begin
                s.ce_n  = 1'b0;
                s.we_n  = 1'b0;
                s.lb_n  = ~be[0];
                s.ub_n  = ~be[1];
                s.drive = 1'b1;
            end
            default: s = STROBE_QUIET;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/asram_phase_cnt.sv
module asram_phase_cnt #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);

endmodule

// File: rtl/asram_seq.sv
module asram_seq
    import asram_pkg::*;
#(
    parameter int RD_CYC = 2,
    parameter int WR_CYC = 1,
    parameter int TA_CYC = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             req_write,
    input  logic [LANES-1:0] req_be,
    input  logic [LANES-1:0] held_be,
    output logic             idle,
    output logic             capture,
    output logic             done,
    output strobe_t          ctl
);
    localparam int MAX_AB  = (RD_CYC > WR_CYC) ? RD_CYC : WR_CYC;
    localparam int MAX_CYC = (MAX_AB > TA_CYC) ? MAX_AB : TA_CYC;
    localparam int CW      = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC + 1);
    localparam logic [CW-1:0] RD_LD = CW'(RD_CYC - 1);
    localparam logic [CW-1:0] WR_LD = CW'(WR_CYC - 1);
    localparam logic [CW-1:0] TA_LD = CW'(TA_CYC - 1);

    phase_e           state_q, state_d;
    strobe_t          ctl_q;
    logic             done_q, done_d;
    logic             cnt_load, cnt_zero;
    logic [CW-1:0]    cnt_val;
    logic [LANES-1:0] be_d;

    asram_phase_cnt #(.W(CW)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .load     (cnt_load),
        .load_val (cnt_val),
        .zero     (cnt_zero)
    );

    always_comb begin
        state_d  = state_q;
        cnt_load = 1'b0;
        cnt_val  = '0;
        done_d   = 1'b0;
        capture  = 1'b0;
        be_d     = held_be;
        case (state_q)
            ST_IDLE: begin
                if (start) begin
                    be_d = req_be;
                    if (req_be == '0) begin
                        state_d  = ST_TURN;
                        cnt_load = 1'b1;
                        cnt_val  = TA_LD;
                        done_d   = 1'b1;
                    end else if (req_write) begin
                        state_d = ST_WSETUP;
                    end else begin
                        state_d  = ST_READ;
                        cnt_load = 1'b1;
                        cnt_val  = RD_LD;
                    end
                end
            end
            ST_READ: begin
                if (cnt_zero) begin
                    state_d  = ST_TURN;
                    cnt_load = 1'b1;
                    cnt_val  = TA_LD;
                    capture  = 1'b1;
                    done_d   = 1'b1;
                end
            end
            ST_WSETUP: begin
                state_d  = ST_WPULSE;
                cnt_load = 1'b1;
                cnt_val  = WR_LD;
            end
            ST_WPULSE: begin
                if (cnt_zero)
                    state_d = ST_WHOLD;
            end
            ST_WHOLD: begin
                state_d  = ST_TURN;
                cnt_load = 1'b1;
                cnt_val  = TA_LD;
                done_d   = 1'b1;
            end
            ST_TURN: begin
                if (cnt_zero)
                    state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            ctl_q   <= STROBE_QUIET;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            ctl_q   <= strobes_for(state_d, be_d);
            done_q  <= done_d;
        end
    end

    assign idle = (state_q == ST_IDLE);
    assign done = done_q;
    assign ctl  = ctl_q;

    AST_NOOP_SILENT: assert property (@(posedge clk) disable iff (rst)
        (idle && start && req_be == '0) |=> (ctl_q.ce_n && done_q && state_q == ST_TURN)); // R7

    AST_BUSY_NO_START: assert property (@(posedge clk) disable iff (rst)
        (!idle && state_q != ST_TURN) |=> (state_q != ST_IDLE)); // R8

endmodule

// File: rtl/asram_datapath.sv
module asram_datapath
    import asram_pkg::*;
#(
    parameter int ADDR_W = 18
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [LANES-1:0]  req_be,
    input  logic              capture,
    input  strobe_t           ctl,
    input  logic [DATA_W-1:0] dq_in,
    output logic [LANES-1:0]  held_be,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe,
    output logic [DATA_W-1:0] rdata
);
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [LANES-1:0]  be_q;
    logic [DATA_W-1:0] rdata_q;
    logic [DATA_W-1:0] lane_mask;

    generate
        for (genvar l = 0; l < LANES; l++) begin : g_lane
            assign lane_mask[l*LANE_W +: LANE_W] = {LANE_W{be_q[l]}};
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q  <= '0;
            wdata_q <= '0;
            be_q    <= '0;
            rdata_q <= '0;
        end else begin
            if (accept) begin
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
                be_q    <= req_be;
            end
            if (capture)
                rdata_q <= dq_in & lane_mask;
        end
    end

    assign held_be  = be_q;
    assign mem_addr = addr_q;
    assign dq_out   = wdata_q;
    assign dq_oe    = ctl.drive;
    assign rdata    = rdata_q;

    AST_DRIVE_OE_HIGH: assert property (@(posedge clk) disable iff (rst)
        dq_oe |-> ctl.oe_n); // R5

    AST_WDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!ctl.we_n && !$past(ctl.we_n)) |-> $stable(dq_out)); // R6

endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
    import asram_pkg::*;
#(
    parameter int ADDR_W = 18,
    parameter int RD_CYC = 2,
    parameter int WR_CYC = 1,
    parameter int TA_CYC = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [LANES-1:0]  req_be,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_done,
    output logic              sram_ce_n,
    output logic              sram_oe_n,
    output logic              sram_we_n,
    output logic              sram_ub_n,
    output logic              sram_lb_n,
    output logic [ADDR_W-1:0] sram_addr,
    inout  wire  [DATA_W-1:0] sram_dq
);
    logic              idle, accept, capture, dq_oe;
    logic [LANES-1:0]  held_be;
    logic [DATA_W-1:0] dq_out;
    strobe_t           ctl;

    assign accept = req_valid && idle;

    asram_seq #(
        .RD_CYC (RD_CYC),
        .WR_CYC (WR_CYC),
        .TA_CYC (TA_CYC)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (accept),
        .req_write (req_write),
        .req_be    (req_be),
        .held_be   (held_be),
        .idle      (idle),
        .capture   (capture),
        .done      (rsp_done),
        .ctl       (ctl)
    );

    asram_datapath #(.ADDR_W(ADDR_W)) u_dp (
        .clk       (clk),
        .rst       (rst),
        .accept    (accept),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .req_be    (req_be),
        .capture   (capture),
        .ctl       (ctl),
        .dq_in     (sram_dq),
        .held_be   (held_be),
        .mem_addr  (sram_addr),
        .dq_out    (dq_out),
        .dq_oe     (dq_oe),
        .rdata     (rsp_rdata)
    );

    assign req_ready = idle;
    assign sram_ce_n = ctl.ce_n;
    assign sram_oe_n = ctl.oe_n;
    assign sram_we_n = ctl.we_n;
    assign sram_ub_n = ctl.ub_n;
    assign sram_lb_n = ctl.lb_n;
    assign sram_dq   = dq_oe ? dq_out : {DATA_W{1'bz}};

    AST_OE_WE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(!sram_oe_n && !sram_we_n)); // R5

    AST_WE_NEEDS_CE: assert property (@(posedge clk) disable iff (rst)
        !sram_we_n |-> !sram_ce_n); // R6

    AST_ADDR_HOLD_WR: assert property (@(posedge clk) disable iff (rst)
        (!sram_we_n && !$past(sram_we_n)) |-> $stable(sram_addr)); // R6

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        rsp_done |=> !rsp_done); // R10

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (sram_ce_n && sram_we_n && sram_oe_n)); // R9

endmodule

// File: tb/asram_ctrl_test.sv
`timescale 1ns/1ps
module asram_ctrl_test;
    localparam int RD = 2;
    localparam int WR = 1;
    localparam int TA = 1;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [17:0] req_addr  = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_be    = '0;
    logic        req_ready, rsp_done;
    logic [15:0] rsp_rdata;
    logic        ce_n, oe_n, we_n, ub_n, lb_n;
    logic [17:0] sram_addr;
    wire  [15:0] dq;

    int checks = 0;
    int errors = 0;
    int v_oewe = 0, v_addr = 0, v_wece = 0, v_done = 0;

    logic [15:0] mem [256];

    always #4 clk = ~clk;

    asram_ctrl #(.ADDR_W(18), .RD_CYC(RD), .WR_CYC(WR), .TA_CYC(TA)) uut (
        .clk (clk), .rst (rst),
        .req_valid (req_valid), .req_ready (req_ready), .req_write (req_write),
        .req_addr (req_addr), .req_wdata (req_wdata), .req_be (req_be),
        .rsp_rdata (rsp_rdata), .rsp_done (rsp_done),
        .sram_ce_n (ce_n), .sram_oe_n (oe_n), .sram_we_n (we_n),
        .sram_ub_n (ub_n), .sram_lb_n (lb_n), .sram_addr (sram_addr),
        .sram_dq (dq)
    );

    // Memory model: outputs on when selected for reading, capture on write end.
    logic rd_on;
    assign rd_on = !ce_n && !oe_n && we_n;
    assign dq[7:0]  = (rd_on && !lb_n) ? mem[sram_addr[7:0]][7:0]  : 8'hzz;
    assign dq[15:8] = (rd_on && !ub_n) ? mem[sram_addr[7:0]][15:8] : 8'hzz;

    task automatic mem_store();
        if (!lb_n) mem[sram_addr[7:0]][7:0]  = dq[7:0];
        if (!ub_n) mem[sram_addr[7:0]][15:8] = dq[15:8];
    endtask

    always @(posedge we_n) if (!rst && !ce_n) mem_store();
    always @(posedge ce_n) if (!rst && !we_n) mem_store();

    // Protocol monitor sampled between edges.
    logic [17:0] p_addr;
    logic        p_we = 1'b1, p_done = 1'b0;
    always @(negedge clk) begin
        if (!rst) begin
            if (!oe_n && !we_n) v_oewe++;
            if (!we_n && ce_n) v_wece++;
            if (!we_n && !p_we && sram_addr != p_addr) v_addr++;
            if (rsp_done && p_done) v_done++;
        end
        p_addr = sram_addr;
        p_we   = we_n;
        p_done = rsp_done;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    int lat, ce_cnt, oe_cnt, we_cnt, gap, ce_gap_bad;
    logic [15:0] got;

    task automatic do_req(input bit wr, input logic [17:0] a, input logic [15:0] d,
                          input logic [1:0] be);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1; ce_cnt = 0; oe_cnt = 0; we_cnt = 0;
        ce_cnt += int'(!ce_n); oe_cnt += int'(!oe_n); we_cnt += int'(!we_n);
        while (!rsp_done && lat < 100) begin
            @(negedge clk);
            lat++;
            ce_cnt += int'(!ce_n); oe_cnt += int'(!oe_n); we_cnt += int'(!we_n);
        end
        got = rsp_rdata;
        gap = 0; ce_gap_bad = 0;
        while (!req_ready && gap < 100) begin
            if (!ce_n) ce_gap_bad++;
            @(negedge clk);
            gap++;
        end
    endtask

    task automatic t_reset();
        chk(ce_n && oe_n && we_n && ub_n && lb_n, "R1 strobes idle", {ce_n,oe_n,we_n,ub_n,lb_n}, 5'h1f);
        chk(req_ready && !rsp_done, "R1 ready/done", {req_ready,rsp_done}, 2'b10);
    endtask

    task automatic t_full_word();
        do_req(1'b1, 18'h5, 16'h1234, 2'b11);
        chk(lat == WR + 3, "R4 write latency", lat, WR + 3);
        chk(we_cnt == WR, "R4 we low cycles", we_cnt, WR);
        chk(ce_cnt == WR + 2, "R4 ce low cycles", ce_cnt, WR + 2);
        chk(oe_cnt == 0, "R5 oe low during write", oe_cnt, 0);
        chk(gap == TA && ce_gap_bad == 0, "R9 turnaround", gap, TA);
        do_req(1'b0, 18'h5, 16'h0, 2'b11);
        chk(lat == RD + 1, "R2 read latency", lat, RD + 1);
        chk(oe_cnt == RD && ce_cnt == RD && we_cnt == 0, "R2 read strobes", oe_cnt, RD);
        chk(got == 16'h1234, "R2 read data", got, 16'h1234);
        chk(gap == TA, "R9 read turnaround", gap, TA);
    endtask

    task automatic t_bytes();
        do_req(1'b1, 18'h5, 16'hABFF, 2'b01);
        do_req(1'b0, 18'h5, 16'h0, 2'b11);
        chk(got == 16'h12FF, "R3 lower-byte write", got, 16'h12FF);
        do_req(1'b1, 18'h5, 16'hCD00, 2'b10);
        do_req(1'b0, 18'h5, 16'h0, 2'b11);
        chk(got == 16'hCDFF, "R3 upper-byte write", got, 16'hCDFF);
        do_req(1'b0, 18'h5, 16'h0, 2'b01);
        chk(got == 16'h00FF, "R3 lower-only read", got, 16'h00FF);
        do_req(1'b0, 18'h5, 16'h0, 2'b10);
        chk(got == 16'hCD00, "R3 upper-only read", got, 16'hCD00);
    endtask

    task automatic t_noop();
        do_req(1'b1, 18'h5, 16'h0000, 2'b00);
        chk(lat == 1, "R7 noop latency", lat, 1);
        chk(ce_cnt == 0 && we_cnt == 0 && oe_cnt == 0, "R7 noop strobes", ce_cnt + we_cnt + oe_cnt, 0);
        do_req(1'b0, 18'h5, 16'h0, 2'b11);
        chk(got == 16'hCDFF, "R7 noop left memory", got, 16'hCDFF);
    endtask

    task automatic t_busy();
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = 18'h9; req_be = 2'b11;
        @(negedge clk);
        chk(!req_ready, "R8 ready low when busy", req_ready, 0);
        req_write = 1'b1; req_addr = 18'h5; req_wdata = 16'h0000; req_be = 2'b11;
        @(negedge clk);
        req_valid = 1'b0;
        while (!req_ready) @(negedge clk);
        do_req(1'b0, 18'h5, 16'h0, 2'b11);
        chk(got == 16'hCDFF, "R8 busy request ignored", got, 16'hCDFF);
    endtask

    task automatic t_sweep();
        for (int i = 0; i < 8; i++)
            do_req(1'b1, 18'h20 + 18'(i) + (18'(i) << 10), 16'h1111 * 16'(i) ^ 16'h5A5A, 2'b11);
        for (int i = 0; i < 8; i++) begin
            do_req(1'b0, 18'h20 + 18'(i) + (18'(i) << 10), 16'h0, 2'b11);
            chk(got == (16'h1111 * 16'(i) ^ 16'h5A5A), "R2 sweep readback", got, 16'h1111 * 16'(i) ^ 16'h5A5A);
        end
    endtask

    task automatic t_hold();
        do_req(1'b0, 18'h5, 16'h0, 2'b11);
        do_req(1'b1, 18'h6, 16'h7777, 2'b11);
        repeat (3) @(negedge clk);
        chk(rsp_rdata == 16'hCDFF && !rsp_done, "R10 rdata held", rsp_rdata, 16'hCDFF);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 16'h0;
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_full_word();
        t_bytes();
        t_noop();
        t_busy();
        t_sweep();
        t_hold();
        chk(v_oewe == 0, "R5 oe and we low together", v_oewe, 0);
        chk(v_wece == 0, "R6 we low without ce", v_wece, 0);
        chk(v_addr == 0, "R6 address moved during write", v_addr, 0);
        chk(v_done == 0, "R10 done longer than one cycle", v_done, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule